// File: doc/BRIEF.md
# UART register and command front end

This block is the byte-wide register face of one asynchronous serial channel. A host reaches it over a simple select/write bus with a small address space on 4-byte spacing. Some addresses reach different registers on read and on write: the status read shares an address with the clock-select write, the receive buffer with the transmit buffer, the input-port change with auxiliary control, and the interrupt status with the interrupt mask. Two mode registers sit behind one address. An internal pointer selects between them.

Writes to the command register become one-cycle strobes and level controls for the receiver and transmitter that sit outside this block. A modem-control output has its own set address and its own clear address. A CTS input is synchronized and edge-detected. The interrupt sources are combined with a mask into one request line. The serial shifters, baud generation and FIFOs are not part of this block. They connect through the strobe and status ports.

Top module: `uart_regif`

## Requirements
- R1: After reset the following are all 0: rx_en, tx_en, tx_break, rts_out, irq, every strobe, both mode registers, clk_sel, aux_ctrl, divider and the interrupt mask. The mode pointer selects the first mode register.
- R2: An access (read or write) at offset 0x00 reaches the mode register the pointer selects. After every such access the pointer moves to the second mode register and stays there until a command with bits 6:4 = 1 returns it to the first.
- R3: A read at 0x04 returns {break, framing, parity, overrun, tx_empty, tx_ready, rx_full, rx_ready} from bit 7 down to bit 0, with the error inputs taken from rx_err[3:0] in that order. A write at 0x04 loads clk_sel and never changes what 0x04 reads.
- R4: For a write at 0x08, bits 1:0 are the receiver field and bits 3:2 the transmitter field. In each field, 01 sets the enable, 10 clears it, and 00 or 11 leaves it unchanged.
- R5: Command bits 6:4 select an action. Value 2 pulses rx_reset for one cycle and clears rx_en. Value 3 pulses tx_reset, clears tx_en and clears tx_break. Value 4 pulses err_clr. A reset in bits 6:4 overrides an enable in the same byte.
- R6: Command bits 6:4 = 6 sets tx_break and 7 clears it.
- R7: A read at 0x0C returns rx_data, and rx_pop is high for exactly the cycle after that read. A write at 0x0C raises tx_push for the cycle after the write, with the byte on tx_data.
- R8: A write at 0x38 with bit 0 = 1 sets rts_out. A write at 0x3C with bit 0 = 1 clears it. A write at either address with bit 0 = 0 leaves rts_out unchanged.
- R9: A read at 0x10 returns the synchronized CTS level in bit 0 and the change-of-state flag in bit 4. A read at 0x34 returns the CTS level in bit 0. The flag is set by a CTS edge only while aux_ctrl bit 0 is 1, and a read at 0x10 clears it.
- R10: Interrupt status at 0x14 has these bits: bit 0 = tx_ready; bit 1 = rx_full if mode1 bit 6 is 1, otherwise rx_ready; bit 2 = break-change flag; bit 7 = CTS change flag. A write at 0x14 loads the mask. irq is the OR of status AND mask, combinationally.
- R11: A high on brk_change sets the break-change flag. A command with bits 6:4 = 5 clears it.
- R12: Offsets 0x18 and 0x1C hold the high and low divider bytes, which read back and drive divider. Reads at write-only or unmapped offsets return 0, and writes at unmapped offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when idle |
| rx_data | input | 8 | Byte at the head of the receiver |
| rx_ready | input | 1 | Receiver holds a byte |
| rx_full | input | 1 | Receiver storage full |
| rx_err | input | 4 | {break, framing, parity, overrun} |
| tx_ready | input | 1 | Transmitter can take a byte |
| tx_empty | input | 1 | Transmitter fully drained |
| brk_change | input | 1 | Receiver saw break begin or end |
| cts_in | input | 1 | Asynchronous CTS level |
| rx_en | output | 1 | Receiver enable |
| tx_en | output | 1 | Transmitter enable |
| rx_reset | output | 1 | One-cycle receiver reset strobe |
| tx_reset | output | 1 | One-cycle transmitter reset strobe |
| err_clr | output | 1 | One-cycle error-status clear strobe |
| tx_break | output | 1 | Hold the line in break |
| rx_pop | output | 1 | One-cycle receive pop strobe |
| tx_push | output | 1 | One-cycle transmit push strobe |
| tx_data | output | 8 | Byte for the transmitter |
| mode1 | output | 8 | First mode register |
| mode2 | output | 8 | Second mode register |
| clk_sel | output | 8 | Clock-select register |
| aux_ctrl | output | 8 | Auxiliary control register |
| divider | output | 16 | {high byte, low byte} of the divider |
| rts_out | output | 1 | RTS, 1 = asserted |
| irq | output | 1 | Masked interrupt request |

## Verification
The bench uses the default ADDR_W = 6. This leaves holes inside the map, such as 0x24 and 0x01, that the bench reads and writes to show they have no effect. It uses the default SYNC_STAGES = 2 and sizes its wait after each CTS edge from that value, so that the change flag and the input-port level are sampled only after the full synchronizer delay. Random command bytes reach every combination of the receiver, transmitter and action fields, including the reserved 11 codes and resets that collide with enables. Random masks, status inputs and settings of the full-or-ready select check the interrupt combination.

// File: rtl/uart_regif_pkg.sv
package uart_regif_pkg;

  localparam int RegW = 8;
  localparam int OffW = 6;

  // Register offsets (4-byte spacing)
  localparam logic [OffW-1:0] OFF_MODE  = 6'h00;
  localparam logic [OffW-1:0] OFF_STAT  = 6'h04;
  localparam logic [OffW-1:0] OFF_CMD   = 6'h08;
  localparam logic [OffW-1:0] OFF_DATA  = 6'h0C;
  localparam logic [OffW-1:0] OFF_PCHG  = 6'h10;
  localparam logic [OffW-1:0] OFF_INTR  = 6'h14;
  localparam logic [OffW-1:0] OFF_DIVH  = 6'h18;
  localparam logic [OffW-1:0] OFF_DIVL  = 6'h1C;
  localparam logic [OffW-1:0] OFF_PIN   = 6'h34;
  localparam logic [OffW-1:0] OFF_OSET  = 6'h38;
  localparam logic [OffW-1:0] OFF_OCLR  = 6'h3C;

  // Interrupt status / mask bit positions
  localparam int IRQ_TX  = 0;
  localparam int IRQ_RX  = 1;
  localparam int IRQ_BRK = 2;
  localparam int IRQ_COS = 7;

  typedef enum logic [2:0] {
    ACT_NONE    = 3'd0,
    ACT_PTR_RST = 3'd1,
    ACT_RX_RST  = 3'd2,
    ACT_TX_RST  = 3'd3,
    ACT_ERR_CLR = 3'd4,
    ACT_BRK_ACK = 3'd5,
    ACT_BRK_ON  = 3'd6,
    ACT_BRK_OFF = 3'd7
  } misc_act_e;

  typedef struct packed {
    logic rx_on;
    logic rx_off;
    logic tx_on;
    logic tx_off;
    logic ptr_rst;
    logic rx_rst;
    logic tx_rst;
    logic err_clr;
    logic brk_ack;
    logic brk_on;
    logic brk_off;
  } cmd_act_t;

endpackage

// File: rtl/uart_cmd_decode.sv
module uart_cmd_decode
  import uart_regif_pkg::*;
(
  input  logic       cmd_we,
  input  logic [6:0] cmd_byte,
  output cmd_act_t   act
);

  misc_act_e misc;

  always_comb begin
    misc = misc_act_e'(cmd_byte[6:4]);
    act  = '0;
    if (cmd_we) begin
      act.rx_on  = (cmd_byte[1:0] == 2'b01);
      act.rx_off = (cmd_byte[1:0] == 2'b10);
      act.tx_on  = (cmd_byte[3:2] == 2'b01);
      act.tx_off = (cmd_byte[3:2] == 2'b10);
      unique case (misc)
        ACT_PTR_RST: act.ptr_rst = 1'b1;
        ACT_RX_RST:  act.rx_rst  = 1'b1;
        ACT_TX_RST:  act.tx_rst  = 1'b1;
        ACT_ERR_CLR: act.err_clr = 1'b1;
        ACT_BRK_ACK: act.brk_ack = 1'b1;
        ACT_BRK_ON:  act.brk_on  = 1'b1;
        ACT_BRK_OFF: act.brk_off = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/uart_mode_bank.sv
module uart_mode_bank
  import uart_regif_pkg::*;
#(
  parameter int BANKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_en,
  input  logic            wr_en,
  input  logic [RegW-1:0] wdata,
  input  logic            ptr_rst,
  output logic [RegW-1:0] rd_val,
  output logic [RegW-1:0] mode1_o,
  output logic [RegW-1:0] mode2_o
);

  localparam int PtrW = (BANKS > 1) ? $clog2(BANKS) : 1;
  localparam logic [PtrW-1:0] PtrLast = PtrW'(BANKS - 1);

  logic [PtrW-1:0]                ptr_q, ptr_d;
  logic [BANKS-1:0][RegW-1:0]     bank_q;
  logic [BANKS-1:0]               bank_we;

  always_comb begin
    ptr_d = ptr_q;
    if (ptr_rst)
      ptr_d = '0;
    else if (acc_en && ptr_q != PtrLast)
      ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  for (genvar i = 0; i < BANKS; i++) begin : g_bank
    assign bank_we[i] = acc_en && wr_en && (ptr_q == PtrW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[i] <= '0;
      else if (bank_we[i]) bank_q[i] <= wdata;
    end
  end

  assign rd_val  = bank_q[ptr_q];
  assign mode1_o = bank_q[0];
  assign mode2_o = bank_q[BANKS-1];

  // R2: pointer holds on the last register until a reset command
  p_ptr_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_q == PtrLast && !ptr_rst) |=> (ptr_q == PtrLast));

  // R2: reset command returns the pointer to the first register
  p_ptr_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> (ptr_q == '0));

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_regif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cts_in,
  input  logic            iec_en,
  input  logic            chg_rd,
  input  logic            brk_change,
  input  logic            brk_ack,
  input  logic            rx_ready,
  input  logic            rx_full,
  input  logic            tx_ready,
  input  logic            full_mode,
  input  logic            mask_we,
  input  logic [RegW-1:0] mask_in,
  output logic            cts_lvl,
  output logic            cos_flag,
  output logic [RegW-1:0] isr_o,
  output logic            irq
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   cts_prev_q;
  logic                   cos_q, cos_d;
  logic                   brk_q, brk_d;
  logic [RegW-1:0]        mask_q, mask_d;
  logic                   cos_set;

  if (SYNC_STAGES == 1) begin : g_sync1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= cts_in;
    end
  end else begin : g_syncn
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], cts_in};
    end
  end

  assign cts_lvl = sync_q[SYNC_STAGES-1];
  assign cos_set = iec_en && (cts_lvl != cts_prev_q);

  always_comb begin
    cos_d  = cos_q;
    brk_d  = brk_q;
    mask_d = mask_q;
    if (chg_rd)     cos_d = 1'b0;
    if (cos_set)    cos_d = 1'b1;
    if (brk_ack)    brk_d = 1'b0;
    if (brk_change) brk_d = 1'b1;
    if (mask_we)    mask_d = mask_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_prev_q <= 1'b0;
      cos_q      <= 1'b0;
      brk_q      <= 1'b0;
      mask_q     <= '0;
    end else begin
      cts_prev_q <= cts_lvl;
      cos_q      <= cos_d;
      brk_q      <= brk_d;
      mask_q     <= mask_d;
    end
  end

  always_comb begin
    isr_o          = '0;
    isr_o[IRQ_TX]  = tx_ready;
    isr_o[IRQ_RX]  = full_mode ? rx_full : rx_ready;
    isr_o[IRQ_BRK] = brk_q;
    isr_o[IRQ_COS] = cos_q;
  end

  assign cos_flag = cos_q;
  assign irq      = |(isr_o & mask_q);

  // R9: flag only rises while detection is enabled
  p_cos_needs_iec_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cos_q) |-> $past(iec_en));

  // R9: reading the change register clears the flag
  p_cos_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_rd && !cos_set) |=> !cos_q);

  // R10: a request needs some live source
  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (tx_ready || rx_ready || rx_full || cos_q || brk_q));

  // R11: break-change flag clears on acknowledge
  p_brk_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ack && !brk_change) |=> !brk_q);

endmodule

// File: rtl/uart_regif.sv
module uart_regif
  import uart_regif_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [RegW-1:0]   bus_wdata,
  output logic [RegW-1:0]   bus_rdata,
  input  logic [RegW-1:0]   rx_data,
  input  logic              rx_ready,
  input  logic              rx_full,
  input  logic [3:0]        rx_err,
  input  logic              tx_ready,
  input  logic              tx_empty,
  input  logic              brk_change,
  input  logic              cts_in,
  output logic              rx_en,
  output logic              tx_en,
  output logic              rx_reset,
  output logic              tx_reset,
  output logic              err_clr,
  output logic              tx_break,
  output logic              rx_pop,
  output logic              tx_push,
  output logic [RegW-1:0]   tx_data,
  output logic [RegW-1:0]   mode1,
  output logic [RegW-1:0]   mode2,
  output logic [RegW-1:0]   clk_sel,
  output logic [RegW-1:0]   aux_ctrl,
  output logic [2*RegW-1:0] divider,
  output logic              rts_out,
  output logic              irq
);

  localparam int DivW = 2 * RegW;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [OffW-1:0] off);
    return a == ADDR_W'(off);
  endfunction

  logic rd_acc, wr_acc;
  logic h_mode, h_stat, h_cmd, h_data, h_pchg, h_intr;
  logic h_divh, h_divl, h_pin, h_oset, h_oclr;

  assign rd_acc = bus_sel && !bus_wr;
  assign wr_acc = bus_sel && bus_wr;
  assign h_mode = at(bus_addr, OFF_MODE);
  assign h_stat = at(bus_addr, OFF_STAT);
  assign h_cmd  = at(bus_addr, OFF_CMD);
  assign h_data = at(bus_addr, OFF_DATA);
  assign h_pchg = at(bus_addr, OFF_PCHG);
  assign h_intr = at(bus_addr, OFF_INTR);
  assign h_divh = at(bus_addr, OFF_DIVH);
  assign h_divl = at(bus_addr, OFF_DIVL);
  assign h_pin  = at(bus_addr, OFF_PIN);
  assign h_oset = at(bus_addr, OFF_OSET);
  assign h_oclr = at(bus_addr, OFF_OCLR);

  cmd_act_t        act;
  logic [RegW-1:0] mode_rd;
  logic            cts_lvl, cos_flag;
  logic [RegW-1:0] isr;

  uart_cmd_decode u_cmd (
    .cmd_we   (wr_acc && h_cmd),
    .cmd_byte (bus_wdata[6:0]),
    .act      (act)
  );

  uart_mode_bank #(.BANKS(2)) u_mode (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (bus_sel && h_mode),
    .wr_en   (bus_wr),
    .wdata   (bus_wdata),
    .ptr_rst (act.ptr_rst),
    .rd_val  (mode_rd),
    .mode1_o (mode1),
    .mode2_o (mode2)
  );

  uart_irq_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .cts_in     (cts_in),
    .iec_en     (aux_ctrl[0]),
    .chg_rd     (rd_acc && h_pchg),
    .brk_change (brk_change),
    .brk_ack    (act.brk_ack),
    .rx_ready   (rx_ready),
    .rx_full    (rx_full),
    .tx_ready   (tx_ready),
    .full_mode  (mode1[6]),
    .mask_we    (wr_acc && h_intr),
    .mask_in    (bus_wdata),
    .cts_lvl    (cts_lvl),
    .cos_flag   (cos_flag),
    .isr_o      (isr),
    .irq        (irq)
  );

  // Control state
  logic            rx_en_q, rx_en_d, tx_en_q, tx_en_d, brk_q, brk_d;
  logic            rts_q, rts_d;
  logic [RegW-1:0] csel_q, csel_d, aux_q, aux_d, txd_q, txd_d;
  logic [DivW-1:0] div_q, div_d;
  logic            pop_d, push_d, rxr_d, txr_d, errc_d;
  logic            pop_q, push_q, rxr_q, txr_q, errc_q;

  always_comb begin
    rx_en_d = rx_en_q;
    tx_en_d = tx_en_q;
    brk_d   = brk_q;
    rts_d   = rts_q;
    csel_d  = csel_q;
    aux_d   = aux_q;
    txd_d   = txd_q;
    div_d   = div_q;

    if (act.rx_rst || act.rx_off) rx_en_d = 1'b0;
    else if (act.rx_on)           rx_en_d = 1'b1;
    if (act.tx_rst || act.tx_off) tx_en_d = 1'b0;
    else if (act.tx_on)           tx_en_d = 1'b1;
    if (act.tx_rst || act.brk_off) brk_d = 1'b0;
    else if (act.brk_on)           brk_d = 1'b1;

    if (wr_acc && h_oset && bus_wdata[0]) rts_d = 1'b1;
    if (wr_acc && h_oclr && bus_wdata[0]) rts_d = 1'b0;
    if (wr_acc && h_stat) csel_d = bus_wdata;
    if (wr_acc && h_pchg) aux_d  = bus_wdata;
    if (wr_acc && h_divh) div_d[DivW-1:RegW] = bus_wdata;
    if (wr_acc && h_divl) div_d[RegW-1:0]    = bus_wdata;
    if (wr_acc && h_data) txd_d  = bus_wdata;

    pop_d  = rd_acc && h_data;
    push_d = wr_acc && h_data;
    rxr_d  = act.rx_rst;
    txr_d  = act.tx_rst;
    errc_d = act.err_clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
      brk_q   <= 1'b0;
      rts_q   <= 1'b0;
      csel_q  <= '0;
      aux_q   <= '0;
      txd_q   <= '0;
      div_q   <= '0;
      pop_q   <= 1'b0;
      push_q  <= 1'b0;
      rxr_q   <= 1'b0;
      txr_q   <= 1'b0;
      errc_q  <= 1'b0;
    end else begin
      rx_en_q <= rx_en_d;
      tx_en_q <= tx_en_d;
      brk_q   <= brk_d;
      rts_q   <= rts_d;
      csel_q  <= csel_d;
      aux_q   <= aux_d;
      txd_q   <= txd_d;
      div_q   <= div_d;
      pop_q   <= pop_d;
      push_q  <= push_d;
      rxr_q   <= rxr_d;
      txr_q   <= txr_d;
      errc_q  <= errc_d;
    end
  end

  // Read multiplexer: read and write meanings differ per offset
  always_comb begin
    bus_rdata = '0;
    if (rd_acc) begin
      if (h_mode)      bus_rdata = mode_rd;
      else if (h_stat) bus_rdata = {rx_err, tx_empty, tx_ready, rx_full, rx_ready};
      else if (h_data) bus_rdata = rx_data;
      else if (h_pchg) bus_rdata = {3'b000, cos_flag, 3'b000, cts_lvl};
      else if (h_intr) bus_rdata = isr;
      else if (h_divh) bus_rdata = div_q[DivW-1:RegW];
      else if (h_divl) bus_rdata = div_q[RegW-1:0];
      else if (h_pin)  bus_rdata = {{(RegW-1){1'b0}}, cts_lvl};
    end
  end

  assign rx_en    = rx_en_q;
  assign tx_en    = tx_en_q;
  assign tx_break = brk_q;
  assign rts_out  = rts_q;
  assign clk_sel  = csel_q;
  assign aux_ctrl = aux_q;
  assign divider  = div_q;
  assign tx_data  = txd_q;
  assign rx_pop   = pop_q;
  assign tx_push  = push_q;
  assign rx_reset = rxr_q;
  assign tx_reset = txr_q;
  assign err_clr  = errc_q;

  // R4: disable code clears the receiver enable
  p_rx_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    act.rx_off |=> !rx_en);

  // R5: receiver reset wins over enable
  p_rx_rst_r5: assert property (@(posedge clk) disable iff (!rst_n)
    act.rx_rst |=> (rx_reset && !rx_en));

  // R6: break start command raises break
  p_brk_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    act.brk_on |=> tx_break);

  // R7: a pop strobe always follows a receive-buffer read
  p_pop_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_pop |-> $past(rd_acc && h_data));

  // R8: set and clear addresses drive RTS
  p_rts_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && h_oset && bus_wdata[0]) |=> rts_out);
  p_rts_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && h_oclr && bus_wdata[0]) |=> !rts_out);

endmodule

// File: tb/uart_regif_test.sv
`timescale 1ns/1ps
module uart_regif_test;

  localparam int AW = 6;
  localparam int SYNC = 2;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [AW-1:0] bus_addr;
  logic [7:0]  bus_wdata, bus_rdata, rx_data, tx_data;
  logic        rx_ready, rx_full, tx_ready, tx_empty, brk_change, cts_in;
  logic [3:0]  rx_err;
  logic        rx_en, tx_en, rx_reset, tx_reset, err_clr, tx_break;
  logic        rx_pop, tx_push, rts_out, irq;
  logic [7:0]  mode1, mode2, clk_sel, aux_ctrl;
  logic [15:0] divider;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uart_regif #(.ADDR_W(AW), .SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_data(rx_data), .rx_ready(rx_ready), .rx_full(rx_full), .rx_err(rx_err),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .brk_change(brk_change), .cts_in(cts_in),
    .rx_en(rx_en), .tx_en(tx_en), .rx_reset(rx_reset), .tx_reset(tx_reset),
    .err_clr(err_clr), .tx_break(tx_break), .rx_pop(rx_pop), .tx_push(tx_push),
    .tx_data(tx_data), .mode1(mode1), .mode2(mode2), .clk_sel(clk_sel),
    .aux_ctrl(aux_ctrl), .divider(divider), .rts_out(rts_out), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bwr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic brd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  function automatic logic [7:0] isr_model(input logic fm, input logic txr, input logic rxr,
                                           input logic rxf, input logic cos, input logic brk);
    logic [7:0] v;
    v = 8'h00;
    v[0] = txr;
    v[1] = fm ? rxf : rxr;
    v[2] = brk;
    v[7] = cos;
    return v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic e_rx, e_tx, e_brk;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; bus_sel = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    rx_data = '0; rx_ready = 0; rx_full = 0; rx_err = '0; tx_ready = 0; tx_empty = 0;
    brk_change = 0; cts_in = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 controls", {rx_en, tx_en, tx_break, rts_out, irq, rx_pop, tx_push, rx_reset, tx_reset, err_clr},
        10'b0);
    chk("R1 registers", {mode1, mode2, clk_sel, aux_ctrl}, 32'h0);
    chk("R1 divider", divider, 16'h0);

    // R2 mode pointer
    bwr(6'h00, 8'h53);
    chk("R2 first write to mode1", {mode1, mode2}, 16'h5300);
    bwr(6'h00, 8'h17);
    chk("R2 second write to mode2", {mode1, mode2}, 16'h5317);
    brd(6'h00, rd); chk("R2 pointer stays on mode2", rd, 8'h17);
    bwr(6'h08, 8'h10);
    brd(6'h00, rd); chk("R2 reset pointer reads mode1", rd, 8'h53);
    brd(6'h00, rd); chk("R2 read advances pointer", rd, 8'h17);

    // R3 status read versus clock select write
    rx_err = 4'b1010; tx_empty = 1; tx_ready = 0; rx_full = 1; rx_ready = 0;
    brd(6'h04, rd); chk("R3 status layout", rd, 8'hA_A);
    bwr(6'h04, 8'hDD);
    chk("R3 clock select written", clk_sel, 8'hDD);
    rx_err = 4'b0101; tx_empty = 0; tx_ready = 1; rx_full = 0; rx_ready = 1;
    brd(6'h04, rd); chk("R3 status unaffected by clk select", rd, 8'h55);
    rx_err = 0; tx_ready = 0; rx_ready = 0;

    // R7 data path strobes
    rx_data = 8'hA5;
    brd(6'h0C, rd); chk("R7 receive data", rd, 8'hA5);
    chk("R7 pop strobe high", rx_pop, 1'b1);
    @(negedge clk); chk("R7 pop strobe one cycle", rx_pop, 1'b0);
    bwr(6'h0C, 8'h3C);
    chk("R7 push strobe and data", {tx_push, tx_data}, {1'b1, 8'h3C});
    @(negedge clk); chk("R7 push one cycle", {tx_push, tx_data}, {1'b0, 8'h3C});

    // R5 directed: reset overrides enable in same byte
    bwr(6'h08, 8'h05);
    chk("R4 enable both", {rx_en, tx_en}, 2'b11);
    bwr(6'h08, 8'h25);
    chk("R5 rx reset beats enable", {rx_en, rx_reset, tx_en}, 3'b011);
    @(negedge clk); chk("R5 rx reset one cycle", rx_reset, 1'b0);
    bwr(6'h08, 8'h60);
    chk("R6 break start", tx_break, 1'b1);
    bwr(6'h08, 8'h30);
    chk("R5 tx reset clears tx enable and break", {tx_en, tx_break, tx_reset}, 3'b001);

    // R4 R5 R6 random command bytes
    e_rx = rx_en; e_tx = tx_en; e_brk = tx_break;
    for (int i = 0; i < 300; i++) begin
      logic [7:0] c;
      logic [2:0] m;
      c = 8'($urandom);
      m = c[6:4];
      if (m == 3'd2 || c[1:0] == 2'b10) e_rx = 0;
      else if (c[1:0] == 2'b01) e_rx = 1;
      if (m == 3'd3 || c[3:2] == 2'b10) e_tx = 0;
      else if (c[3:2] == 2'b01) e_tx = 1;
      if (m == 3'd3 || m == 3'd7) e_brk = 0;
      else if (m == 3'd6) e_brk = 1;
      bwr(6'h08, c);
      chk("R4 R5 R6 random command", {rx_en, tx_en, tx_break, rx_reset, tx_reset, err_clr},
          {e_rx, e_tx, e_brk, m == 3'd2, m == 3'd3, m == 3'd4});
    end

    // R8 RTS set and clear
    bwr(6'h3C, 8'h01);
    bwr(6'h38, 8'hFE); chk("R8 set with bit0 low ignored", rts_out, 1'b0);
    bwr(6'h38, 8'h01); chk("R8 set asserts", rts_out, 1'b1);
    bwr(6'h3C, 8'hFE); chk("R8 clear with bit0 low ignored", rts_out, 1'b1);
    bwr(6'h3C, 8'h01); chk("R8 clear deasserts", rts_out, 1'b0);

    // R9 CTS
    bwr(6'h14, 8'h00);
    bwr(6'h10, 8'h00);
    @(negedge clk); cts_in = 1;
    repeat (SYNC + 3) @(negedge clk);
    brd(6'h34, rd); chk("R9 input port level", rd, 8'h01);
    brd(6'h10, rd); chk("R9 no change flag while disabled", rd, 8'h01);
    bwr(6'h10, 8'h01);
    chk("R9 aux written", aux_ctrl, 8'h01);
    @(negedge clk); cts_in = 0;
    repeat (SYNC + 3) @(negedge clk);
    brd(6'h14, rd); chk("R10 change flag in interrupt status", rd, 8'h80);
    brd(6'h10, rd); chk("R9 change flag set", rd, 8'h10);
    brd(6'h10, rd); chk("R9 change flag cleared by read", rd, 8'h00);
    bwr(6'h10, 8'h00);

    // R11 break change flag
    @(negedge clk); brk_change = 1;
    @(negedge clk); brk_change = 0;
    brd(6'h14, rd); chk("R11 break flag set", rd, 8'h04);
    bwr(6'h14, 8'h04);
    #1 chk("R10 irq from break flag", irq, 1'b1);
    bwr(6'h08, 8'h50);
    #1 chk("R11 break ack clears irq", irq, 1'b0);
    brd(6'h14, rd); chk("R11 break flag cleared", rd, 8'h00);

    // R10 random interrupt combination
    for (int i = 0; i < 100; i++) begin
      logic [7:0] mk, m1, ex;
      logic a, b, f;
      mk = 8'($urandom);
      m1 = 8'($urandom);
      a = 1'($urandom); b = 1'($urandom); f = 1'($urandom);
      bwr(6'h08, 8'h10);
      bwr(6'h00, m1);
      bwr(6'h14, mk);
      @(negedge clk);
      tx_ready = a; rx_ready = b; rx_full = f;
      ex = isr_model(m1[6], a, b, f, 1'b0, 1'b0);
      #1 chk("R10 irq combination", irq, |(ex & mk));
      brd(6'h14, rd); chk("R10 interrupt status", rd, ex);
    end
    tx_ready = 0; rx_ready = 0; rx_full = 0;

    // R12 divider and unmapped space
    bwr(6'h18, 8'h12);
    bwr(6'h1C, 8'h34);
    chk("R12 divider output", divider, 16'h1234);
    brd(6'h18, rd); chk("R12 divider high read", rd, 8'h12);
    brd(6'h1C, rd); chk("R12 divider low read", rd, 8'h34);
    brd(6'h08, rd); chk("R12 command reads zero", rd, 8'h00);
    brd(6'h24, rd); chk("R12 unmapped reads zero", rd, 8'h00);
    bwr(6'h24, 8'hFF);
    bwr(6'h01, 8'hFF);
    chk("R12 unmapped write no effect", {clk_sel, aux_ctrl, divider, 7'b0, rts_out},
        {8'hDD, 8'h00, 16'h1234, 8'h00});
    brd(6'h18, rd); chk("R12 divider kept", rd, 8'h12);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule